// File: doc/BRIEF.md
# Banked Cacheability Remap Register

This block is a 32-bit system control register that translates a 3-bit memory attribute index into a pair of 2-bit cacheability codes. One code is for the inner cache levels and one is for the outer levels. The register keeps two copies, one secure and one non-secure. A coprocessor-style access port reads and writes these copies. Every access is checked against the requester's privilege level, against the hypervisor trap controls, and against two inputs that lock secure writes.

An access is a one-cycle request. It carries a privilege level, a direction and write data. One cycle later the block answers with a single-cycle response pulse. The response holds either the read data, an undefined-instruction flag, or a hypervisor trap flag with its code.

A separate combinational lookup port takes the three attribute bits {TEX[0], C, B} and a bank select. It returns the inner and outer codes for that index, so the mapping can be used and observed without going through the access path.

Top module: `attr_remap_reg`

## Requirements
- R1: On synchronous active-high reset, both copies clear to 0x00000000, and all response outputs are low or zero.
- R2: The lookup index is n = {attrTex0, attrC, attrB}. `lkInner` equals bits [2n+1:2n] and `lkOuter` equals bits [2n+17:2n+16] of the copy chosen by `lkSecure` (1 = secure, 0 = non-secure). The lookup is combinational. The codes mean: 00 = non-cacheable, 01 = write-back with allocate, 10 = write-through without allocate, 11 = write-back without allocate.
- R3: Any access with `reqLevel` = 0 gives `rspUndef` and changes neither copy.
- R4: At `reqLevel` = 1 with `hypEnabled` high, a high `hypTrapAll` traps both reads and writes. The trap raises `rspTrap` with `rspTrapCode` = 0x03, changes nothing, and takes priority over the per-direction trap enables.
- R5: At `reqLevel` = 1 with `hypEnabled` high and `hypTrapAll` low, `hypTrapRead` traps only reads and `hypTrapWrite` traps only writes, with code 0x03. An access in the other direction completes normally.
- R6: The trap inputs have no effect when `hypEnabled` is low, or when `reqLevel` is 2 or 3.
- R7: Accesses at `reqLevel` 1 and 2 always use the non-secure copy.
- R8: At `reqLevel` = 3, `nsBit` = 0 selects the secure copy and `nsBit` = 1 selects the non-secure copy.
- R9: At `reqLevel` = 3 with `nsBit` = 0, a write gives `rspUndef` and changes nothing if `secWrLockA` or `secWrLockB` is high. Reads are unaffected by these inputs, and so are writes with `nsBit` = 1.
- R10: The response appears in the cycle after the request and lasts one cycle. `rspRdata` carries the copy's value only for a permitted read and is zero otherwise. `rspValid` is low in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLevel | input | 2 | Privilege level 0..3 of the requester |
| reqWdata | input | 32 | Write data |
| nsBit | input | 1 | Security state at level 3 (1 = non-secure) |
| hypEnabled | input | 1 | Hypervisor level enabled |
| hypTrapAll | input | 1 | Trap all accesses from level 1 |
| hypTrapRead | input | 1 | Trap reads from level 1 |
| hypTrapWrite | input | 1 | Trap writes from level 1 |
| secWrLockA | input | 1 | Secure write lock, first input |
| secWrLockB | input | 1 | Secure write lock, second input |
| attrTex0 | input | 1 | Attribute index bit 2 |
| attrC | input | 1 | Attribute index bit 1 |
| attrB | input | 1 | Attribute index bit 0 |
| lkSecure | input | 1 | Lookup copy select (1 = secure) |
| lkInner | output | 2 | Inner cacheability code |
| lkOuter | output | 2 | Outer cacheability code |
| rspValid | output | 1 | Response pulse |
| rspRdata | output | 32 | Read data |
| rspUndef | output | 1 | Undefined-instruction pulse |
| rspTrap | output | 1 | Hypervisor trap pulse |
| rspTrapCode | output | 8 | Trap code, 0x03 when trapping |

## Verification
The bench checks the trap priority. A design that tested the per-direction enables before `hypTrapAll`, or that let a read trap block writes, would complete accesses that should trap. It also confirms that trap inputs do nothing at levels 2 and 3 or with the hypervisor disabled. A design that forgot either condition would raise spurious traps.

Copy selection is checked by writing distinct values through each path and reading them back both ways. A design that picked the copy by `nsBit` at every level would let level 1 reach the secure copy. The secure write locks are exercised one at a time, on reads and on non-secure writes. The bench then reads back after every refused write, which catches a design that flags undefined but still stores the data.

// File: rtl/attr_remap_pkg.sv
package attr_remap_pkg;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  typedef enum logic [1:0] {
    CACHE_NONE       = 2'b00,
    CACHE_WB_ALLOC   = 2'b01,
    CACHE_WT         = 2'b10,
    CACHE_WB_NOALLOC = 2'b11
  } cache_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrSec;
    logic wrNs;
    logic rdEn;
    logic rdSec;
  } strobe_t;

endpackage

// File: rtl/attr_remap_ctrl.sv
module attr_remap_ctrl
  import attr_remap_pkg::*;
#(
  parameter int TRAP_W = 8,
  parameter logic [TRAP_W-1:0] TRAP_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqLevel,
  input  logic              nsBit,
  input  logic              hypEnabled,
  input  logic              hypTrapAll,
  input  logic              hypTrapRead,
  input  logic              hypTrapWrite,
  input  logic              secWrLockA,
  input  logic              secWrLockB,
  output strobe_t           strobe,
  output logic              rspValid,
  output logic              rspUndef,
  output logic              rspTrap,
  output logic [TRAP_W-1:0] rspTrapCode
);

  level_e lvl;
  logic   isUndef;
  logic   isTrap;
  logic   secBank;
  logic   allowed;

  assign lvl = level_e'(reqLevel);

  always_comb begin
    isUndef = 1'b0;
    isTrap  = 1'b0;
    secBank = (lvl == LVL_MON) && !nsBit;
    case (lvl)
      LVL_USER: isUndef = 1'b1;
      LVL_KERNEL: begin
        if (hypEnabled) begin
          if (hypTrapAll)                   isTrap = 1'b1;
          else if (!reqWrite && hypTrapRead) isTrap = 1'b1;
          else if (reqWrite && hypTrapWrite) isTrap = 1'b1;
        end
      end
      LVL_MON: begin
        if (reqWrite && !nsBit && (secWrLockA || secWrLockB)) isUndef = 1'b1;
      end
      default: ;
    endcase
    allowed      = reqValid && !isUndef && !isTrap;
    strobe.wrSec = allowed && reqWrite && secBank;
    strobe.wrNs  = allowed && reqWrite && !secBank;
    strobe.rdEn  = allowed && !reqWrite;
    strobe.rdSec = secBank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid    <= 1'b0;
      rspUndef    <= 1'b0;
      rspTrap     <= 1'b0;
      rspTrapCode <= '0;
    end else begin
      rspValid    <= reqValid;
      rspUndef    <= reqValid && isUndef;
      rspTrap     <= reqValid && isTrap;
      rspTrapCode <= (reqValid && isTrap) ? TRAP_CODE : '0;
    end
  end

endmodule

// File: rtl/attr_remap_dp.sv
module attr_remap_dp
  import attr_remap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic              lkSecure,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] lkInner,
  output logic [CODE_W-1:0] lkOuter
);

  localparam int NUM_BANKS  = 2;
  localparam int NUM_FIELDS = 1 << IDX_W;
  localparam int OUTER_OFS  = DATA_W / 2;

  // index 0 = non-secure, 1 = secure
  logic [NUM_BANKS-1:0][DATA_W-1:0] banks;
  logic [NUM_BANKS-1:0]             wrEn;
  logic [DATA_W-1:0]                lkWord;
  logic [NUM_FIELDS-1:0][CODE_W-1:0] innerF;
  logic [NUM_FIELDS-1:0][CODE_W-1:0] outerF;

  assign wrEn = {strobe.wrSec, strobe.wrNs};

  always_ff @(posedge clk) begin
    if (rst) begin
      banks <= '0;
      rdata <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wrEn[b]) banks[b] <= wdata;
      end
      rdata <= strobe.rdEn ? banks[strobe.rdSec] : '0;
    end
  end

  assign lkWord = banks[lkSecure];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    assign innerF[g] = lkWord[CODE_W*g +: CODE_W];
    assign outerF[g] = lkWord[OUTER_OFS + CODE_W*g +: CODE_W];
  end

  assign lkInner = innerF[lkIdx];
  assign lkOuter = outerF[lkIdx];

endmodule

// File: rtl/attr_remap_reg.sv
module attr_remap_reg
  import attr_remap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int CODE_W = 2,
  parameter int TRAP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqLevel,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              nsBit,
  input  logic              hypEnabled,
  input  logic              hypTrapAll,
  input  logic              hypTrapRead,
  input  logic              hypTrapWrite,
  input  logic              secWrLockA,
  input  logic              secWrLockB,
  input  logic              attrTex0,
  input  logic              attrC,
  input  logic              attrB,
  input  logic              lkSecure,
  output logic [CODE_W-1:0] lkInner,
  output logic [CODE_W-1:0] lkOuter,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspUndef,
  output logic              rspTrap,
  output logic [TRAP_W-1:0] rspTrapCode
);

  strobe_t strobe;

  attr_remap_ctrl #(.TRAP_W(TRAP_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLevel(reqLevel),
    .nsBit(nsBit), .hypEnabled(hypEnabled),
    .hypTrapAll(hypTrapAll), .hypTrapRead(hypTrapRead), .hypTrapWrite(hypTrapWrite),
    .secWrLockA(secWrLockA), .secWrLockB(secWrLockB),
    .strobe(strobe),
    .rspValid(rspValid), .rspUndef(rspUndef), .rspTrap(rspTrap),
    .rspTrapCode(rspTrapCode)
  );

  attr_remap_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst(rst),
    .strobe(strobe), .wdata(reqWdata),
    .lkIdx({attrTex0, attrC, attrB}), .lkSecure(lkSecure),
    .rdata(rspRdata), .lkInner(lkInner), .lkOuter(lkOuter)
  );

endmodule

// File: rtl/attr_remap_chk.sv
module attr_remap_chk #(
  parameter int TRAP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [1:0]        reqLevel,
  input logic              nsBit,
  input logic              hypEnabled,
  input logic              hypTrapAll,
  input logic              secWrLockA,
  input logic              secWrLockB,
  input logic              rspValid,
  input logic              rspUndef,
  input logic              rspTrap,
  input logic [TRAP_W-1:0] rspTrapCode
);

  p_user_undef_r3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel == 2'd0) |=> (rspUndef && !rspTrap));

  p_trap_all_r4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel == 2'd1 && hypEnabled && hypTrapAll) |=> (rspTrap && rspTrapCode == 8'h03));

  p_secure_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && reqLevel == 2'd3 && !nsBit && (secWrLockA || secWrLockB)) |=> rspUndef);

  p_no_req_no_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!rspValid && !rspUndef && !rspTrap));

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(rspUndef && rspTrap));

  p_high_level_no_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqLevel[1]) |=> !rspTrap);

endmodule

bind attr_remap_reg attr_remap_chk #(.TRAP_W(TRAP_W)) u_chk (.*);

// File: tb/tb_attr_remap_reg.sv
module tb_attr_remap_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid = 0, reqWrite = 0;
  logic [1:0]  reqLevel = 0;
  logic [31:0] reqWdata = 0;
  logic        nsBit = 0, hypEnabled = 0, hypTrapAll = 0, hypTrapRead = 0, hypTrapWrite = 0;
  logic        secWrLockA = 0, secWrLockB = 0;
  logic        attrTex0 = 0, attrC = 0, attrB = 0, lkSecure = 0;
  logic [1:0]  lkInner, lkOuter;
  logic        rspValid, rspUndef, rspTrap;
  logic [31:0] rspRdata;
  logic [7:0]  rspTrapCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // captured response
  logic        gValid, gUndef, gTrap;
  logic [31:0] gData;
  logic [7:0]  gCode;

  always #5 clk = ~clk;

  attr_remap_reg dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic [1:0] lvl, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqLevel = lvl; reqWdata = wd;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; reqWdata = 0;
    gValid = rspValid; gUndef = rspUndef; gTrap = rspTrap;
    gData = rspRdata; gCode = rspTrapCode;
  endtask

  task automatic expectOk(input string req, input logic [31:0] expData);
    chk({req, " valid"}, 32'(gValid), 32'd1);
    chk({req, " undef"}, 32'(gUndef), 32'd0);
    chk({req, " trap"},  32'(gTrap),  32'd0);
    chk({req, " data"},  gData, expData);
  endtask

  task automatic expectUndef(input string req);
    chk({req, " undef"}, 32'(gUndef), 32'd1);
    chk({req, " trap"},  32'(gTrap),  32'd0);
    chk({req, " data"},  gData, 32'd0);
  endtask

  task automatic expectTrap(input string req);
    chk({req, " trap"},  32'(gTrap), 32'd1);
    chk({req, " code"},  32'(gCode), 32'h03);
    chk({req, " undef"}, 32'(gUndef), 32'd0);
    chk({req, " data"},  gData, 32'd0);
  endtask

  task automatic readNs(input string req, input logic [31:0] exp);
    access(2'd2, 0, 0);
    expectOk(req, exp);
  endtask

  task automatic readSec(input string req, input logic [31:0] exp);
    nsBit = 0;
    access(2'd3, 0, 0);
    expectOk(req, exp);
  endtask

  task automatic testReset();
    chk("R1 valid after reset", 32'(rspValid), 0);
    chk("R1 undef after reset", 32'(rspUndef), 0);
    chk("R1 trap after reset", 32'(rspTrap), 0);
    readNs("R1 ns copy", 32'h0);
    readSec("R1 secure copy", 32'h0);
  endtask

  task automatic testBanks();
    access(2'd1, 1, 32'hA5A5_1234);
    expectOk("R7 write level1", 32'h0);
    readNs("R7 level2 read", 32'hA5A5_1234);
    access(2'd1, 0, 0);
    expectOk("R7 level1 read", 32'hA5A5_1234);
    readSec("R7 secure untouched", 32'h0);
    nsBit = 0;
    access(2'd3, 1, 32'h1B2C_E4F9);
    expectOk("R8 secure write", 32'h0);
    nsBit = 1;
    access(2'd3, 0, 0);
    expectOk("R8 ns read at level3", 32'hA5A5_1234);
    readSec("R8 secure read", 32'h1B2C_E4F9);
    nsBit = 1;
    access(2'd3, 1, 32'h5566_7788);
    readNs("R8 ns write at level3", 32'h5566_7788);
    readSec("R8 secure kept", 32'h1B2C_E4F9);
  endtask

  task automatic testLookup();
    logic [31:0] v;
    for (int s = 0; s < 2; s++) begin
      lkSecure = s[0];
      v = s[0] ? 32'h1B2C_E4F9 : 32'h5566_7788;
      for (int n = 0; n < 8; n++) begin
        {attrTex0, attrC, attrB} = 3'(n);
        #1;
        chk("R2 inner", 32'(lkInner), (v >> (2*n)) & 32'h3);
        chk("R2 outer", 32'(lkOuter), (v >> (16 + 2*n)) & 32'h3);
      end
    end
  endtask

  task automatic testUser();
    access(2'd0, 1, 32'hFFFF_FFFF);
    expectUndef("R3 user write");
    access(2'd0, 0, 0);
    expectUndef("R3 user read");
    readNs("R3 ns unchanged", 32'h5566_7788);
  endtask

  task automatic testTraps();
    hypEnabled = 1; hypTrapAll = 1;
    access(2'd1, 0, 0);
    expectTrap("R4 trap-all read");
    access(2'd1, 1, 32'h0BAD_0BAD);
    expectTrap("R4 trap-all write");
    readNs("R4 state unchanged", 32'h5566_7788);
    hypTrapAll = 0; hypTrapRead = 1;
    access(2'd1, 0, 0);
    expectTrap("R5 read trap on read");
    access(2'd1, 1, 32'h0000_00C3);
    expectOk("R5 read trap lets write", 32'h0);
    readNs("R5 write landed", 32'h0000_00C3);
    hypTrapRead = 0; hypTrapWrite = 1;
    access(2'd1, 1, 32'hDEAD_BEEF);
    expectTrap("R5 write trap on write");
    access(2'd1, 0, 0);
    expectOk("R5 write trap lets read", 32'h0000_00C3);
    hypTrapAll = 1; hypTrapRead = 1;
    access(2'd2, 1, 32'h0F0F_0F0F);
    expectOk("R6 level2 ignores traps", 32'h0);
    nsBit = 1;
    access(2'd3, 0, 0);
    expectOk("R6 level3 ignores traps", 32'h0F0F_0F0F);
    hypEnabled = 0;
    access(2'd1, 0, 0);
    expectOk("R6 hyp disabled", 32'h0F0F_0F0F);
    hypTrapAll = 0; hypTrapRead = 0; hypTrapWrite = 0;
  endtask

  task automatic testLocks();
    nsBit = 0; secWrLockA = 1;
    access(2'd3, 1, 32'h7777_7777);
    expectUndef("R9 lockA write");
    access(2'd3, 0, 0);
    expectOk("R9 lockA read allowed", 32'h1B2C_E4F9);
    secWrLockA = 0; secWrLockB = 1;
    access(2'd3, 1, 32'h8888_8888);
    expectUndef("R9 lockB write");
    nsBit = 1;
    access(2'd3, 1, 32'h2468_ACE0);
    expectOk("R9 ns write with lock", 32'h0);
    secWrLockB = 0;
    readSec("R9 secure unchanged", 32'h1B2C_E4F9);
    readNs("R9 ns written", 32'h2468_ACE0);
  endtask

  task automatic testTiming();
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqLevel = 2'd2;
    #1;
    chk("R10 no same-cycle response", 32'(rspValid), 0);
    @(negedge clk);
    reqValid = 0;
    chk("R10 response next cycle", 32'(rspValid), 1);
    chk("R10 data next cycle", rspRdata, 32'h2468_ACE0);
    @(negedge clk);
    chk("R10 single-cycle pulse", 32'(rspValid), 0);
    chk("R10 data cleared", rspRdata, 0);
    access(2'd2, 1, 32'h1111_2222);
    chk("R10 write gives zero data", gData, 0);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    testReset();
    testBanks();
    testLookup();
    testUser();
    testTraps();
    testLocks();
    testTiming();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule